// File: doc/BRIEF.md
# Colour Subcarrier Synthesizer and Quadrature Chroma Modulator

This block builds a digital colour subcarrier from a 32-bit phase accumulator and uses it to fold the two colour-difference samples (Cb and Cr) into a single signed chrominance stream. Software sets the per-pixel phase increment, which fixes the subcarrier frequency, and a line phase offset. The accumulator moves forward only on cycles where the pixel-rate enable is high, so the block runs from the fast system clock while stepping at pixel rate.

A line-start pulse does three things. It loads the offset that software wrote, so a new phase never lands in the middle of a line. Optionally, it clears the accumulator. In the alternating-line (PAL) mode, it also flips the sign applied to the Cr term. A burst gate input replaces the picture samples with fixed burst components while the colour burst is being inserted. Band-limiting, interpolation and conversion to analog take place downstream.

Top module: `chroma_qmod`

## Requirements
- R1: While rst_n is low, chroma_out is 0 and chroma_vld is 0. The phase accumulator, the active offset and the line-alternation flag all clear to 0.
- R2: At each clock where pix_en is high, the 32-bit accumulator adds freq_inc, wrapping modulo 2^32. When pix_en is low, it holds its value unless R9 applies.
- R3: The lookup address P is the 10-bit sum accumulator[31:22] + active offset, wrapping. Let h = P[8:0], a = 2h+1 and p = a(1024-a). The sine magnitude is floor(8176·p / (5242880 − 4p)), and it is negated when P[9] = 1. The cosine is the same function at P+256, taken modulo 1024.
- R4: Cb and Cr are signed two's complement 8-bit inputs. For a clock with pix_en high, the clock edge after it sets chroma_out to sat(floor((Cb·sin + Cr'·cos + 64) / 128)). All terms are taken from the values before that edge. chroma_vld is high in exactly the cycle that follows each pix_en cycle.
- R5: The result saturates to the signed 10-bit range [-512, 511].
- R6: phase_ofs moves into the active offset only at a clock with line_start high. A change at any other time does not alter the output.
- R7: When pal_mode is 1, each line_start toggles the alternation flag. While the flag is 1, Cr' = −Cr. Otherwise, Cr' = Cr.
- R8: When pal_mode is 0, a line_start clears the alternation flag, and Cr is never negated.
- R9: A clock with line_start and line_reset both high sets the accumulator to 0, even when pix_en is high. A line_start with line_reset low leaves the accumulator following R2.
- R10: While burst_gate is high, Cb is replaced by −48. Cr is replaced by +48 in PAL mode and by 0 otherwise. The R7 sign rule still applies to the replaced Cr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel-rate enable: modulate and advance the phase |
| line_start | input | 1 | One-cycle pulse at the start of a line |
| pal_mode | input | 1 | 1 = alternating-line Cr sign, 0 = fixed sign |
| line_reset | input | 1 | 1 = clear the accumulator at each line start |
| freq_inc | input | 32 | Phase increment per pixel |
| phase_ofs | input | 10 | Phase offset register, applied at line start |
| burst_gate | input | 1 | Replace Cb/Cr with burst components |
| cb_in | input | 8 | Signed Cb sample |
| cr_in | input | 8 | Signed Cr sample |
| chroma_out | output | 10 | Signed modulated chroma sample |
| chroma_vld | output | 1 | chroma_out holds a new sample |

## Verification
The assertions check the cycle-level bookkeeping on every cycle:
- the accumulator advances or holds,
- the active offset changes only at a line start,
- the alternation flag toggles in PAL mode and clears otherwise,
- the line reset clears the accumulator,
- chroma_vld follows pix_en,
- the output clamps whenever the rounded sum leaves the 10-bit range.

The numeric value of each chroma sample is checked only by the bench's scoreboard. This covers the sine lookup, the quadrant mirroring, the rounding and the burst substitution. The scoreboard also runs scenarios that exercise the timing of a mid-line offset write, pixel gaps and PAL sign inversion across several lines.

// File: rtl/chroma_qmod_pkg.sv
package chroma_qmod_pkg;
  localparam int PH_W    = 10;            // lookup address bits
  localparam int QW_BITS = PH_W - 2;      // quarter-wave index bits
  localparam int QW_N    = 1 << QW_BITS;
  localparam int AMP_W   = 9;             // magnitude bits
  localparam int AMP_MAX = (1 << AMP_W) - 1;
  localparam int TRIG_W  = AMP_W + 1;     // signed sine/cosine width

  // Rational sine approximation over the first quarter wave,
  // sampled at bin centres (k + 0.5) of a half wave of 2*QW_N bins.
  function automatic logic [AMP_W-1:0] qw_amp(input int k);
    longint a, p, num, den;
    a   = 2 * longint'(k) + 1;
    p   = a * (4 * QW_N - a);
    num = 16 * longint'(AMP_MAX) * p;
    den = 5 * (16 * longint'(QW_N) * longint'(QW_N)) - 4 * p;
    return AMP_W'(num / den);
  endfunction
endpackage

// File: rtl/cq_phase_acc.sv
module cq_phase_acc #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic             line_start,
  input  logic             pal_mode,
  input  logic             line_reset,
  input  logic [ACC_W-1:0] freq_inc,
  input  logic [PH_W-1:0]  phase_ofs,
  output logic [ACC_W-1:0] acc_q,
  output logic [PH_W-1:0]  ofs_q,
  output logic             alt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      ofs_q <= '0;
      alt_q <= 1'b0;
    end else begin
      if (line_start && line_reset) acc_q <= '0;
      else if (pix_en)              acc_q <= acc_q + freq_inc;
      if (line_start) begin
        ofs_q <= phase_ofs;
        alt_q <= pal_mode ? ~alt_q : 1'b0;
      end
    end
  end
endmodule

// File: rtl/cq_sine_lut.sv
module cq_sine_lut
  import chroma_qmod_pkg::*;
(
  input  logic [PH_W-1:0]          addr,
  output logic signed [TRIG_W-1:0] val
);
  logic [AMP_W-1:0]   rom [QW_N];
  logic [QW_BITS-1:0] idx;
  logic [AMP_W-1:0]   mag;

  for (genvar gi = 0; gi < QW_N; gi++) begin : g_rom
    assign rom[gi] = qw_amp(gi);
  end

  // second and fourth quadrants read the table backwards
  assign idx = addr[PH_W-2] ? ~addr[QW_BITS-1:0] : addr[QW_BITS-1:0];
  assign mag = rom[idx];
  assign val = addr[PH_W-1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
endmodule

// File: rtl/cq_mixer.sv
module cq_mixer #(
  parameter int IN_W   = 8,
  parameter int TRIG_W = 10,
  parameter int OUT_W  = 10,
  parameter int SHIFT  = 7,
  parameter int SUM_W  = IN_W + TRIG_W + 2
) (
  input  logic signed [IN_W-1:0]   cb,
  input  logic signed [IN_W:0]     cr,
  input  logic signed [TRIG_W-1:0] sin_v,
  input  logic signed [TRIG_W-1:0] cos_v,
  output logic signed [SUM_W-1:0]  sum_rnd,
  output logic signed [OUT_W-1:0]  y
);
  localparam logic signed [SUM_W-1:0] HALF  = SUM_W'(1) <<< (SHIFT - 1);
  localparam logic signed [SUM_W-1:0] Y_MAX = SUM_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] Y_MIN = -SUM_W'(1 << (OUT_W - 1));

  logic signed [SUM_W-1:0] term_u, term_v;

  assign term_u  = SUM_W'(cb) * SUM_W'(sin_v);
  assign term_v  = SUM_W'(cr) * SUM_W'(cos_v);
  assign sum_rnd = (term_u + term_v + HALF) >>> SHIFT;

  always_comb begin
    if (sum_rnd > Y_MAX)      y = Y_MAX[OUT_W-1:0];
    else if (sum_rnd < Y_MIN) y = Y_MIN[OUT_W-1:0];
    else                      y = sum_rnd[OUT_W-1:0];
  end
endmodule

// File: rtl/chroma_qmod.sv
module chroma_qmod
  import chroma_qmod_pkg::*;
#(
  parameter int ACC_W     = 32,
  parameter int IN_W      = 8,
  parameter int OUT_W     = 10,
  parameter int SHIFT     = 7,
  parameter int BURST_AMP = 48
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pix_en,
  input  logic                    line_start,
  input  logic                    pal_mode,
  input  logic                    line_reset,
  input  logic [ACC_W-1:0]        freq_inc,
  input  logic [PH_W-1:0]         phase_ofs,
  input  logic                    burst_gate,
  input  logic signed [IN_W-1:0]  cb_in,
  input  logic signed [IN_W-1:0]  cr_in,
  output logic signed [OUT_W-1:0] chroma_out,
  output logic                    chroma_vld
);
  localparam int SUM_W = IN_W + TRIG_W + 2;
  localparam logic [PH_W-1:0] QUARTER = PH_W'(1 << (PH_W - 2));

  logic [ACC_W-1:0] acc_q;
  logic [PH_W-1:0]  ofs_q;
  logic             alt_q;
  logic [PH_W-1:0]  sin_addr, cos_addr;
  logic signed [TRIG_W-1:0] sin_v, cos_v;
  logic signed [IN_W-1:0]   cb_sel;
  logic signed [IN_W:0]     cr_sel, cr_eff;
  logic             cr_flip;
  logic signed [SUM_W-1:0]  sum_rnd;
  logic signed [OUT_W-1:0]  y_next;

  cq_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_start(line_start),
    .pal_mode(pal_mode), .line_reset(line_reset), .freq_inc(freq_inc),
    .phase_ofs(phase_ofs), .acc_q(acc_q), .ofs_q(ofs_q), .alt_q(alt_q)
  );

  assign sin_addr = acc_q[ACC_W-1 -: PH_W] + ofs_q;
  assign cos_addr = sin_addr + QUARTER;

  cq_sine_lut u_sin (.addr(sin_addr), .val(sin_v));
  cq_sine_lut u_cos (.addr(cos_addr), .val(cos_v));

  assign cb_sel  = burst_gate ? -IN_W'(BURST_AMP) : cb_in;
  assign cr_sel  = burst_gate ? (pal_mode ? (IN_W+1)'(BURST_AMP) : '0)
                              : (IN_W+1)'(cr_in);
  assign cr_flip = pal_mode && alt_q;
  assign cr_eff  = cr_flip ? -cr_sel : cr_sel;

  cq_mixer #(.IN_W(IN_W), .TRIG_W(TRIG_W), .OUT_W(OUT_W), .SHIFT(SHIFT),
             .SUM_W(SUM_W)) u_mix (
    .cb(cb_sel), .cr(cr_eff), .sin_v(sin_v), .cos_v(cos_v),
    .sum_rnd(sum_rnd), .y(y_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chroma_out <= '0;
      chroma_vld <= 1'b0;
    end else begin
      chroma_vld <= pix_en;
      if (pix_en) chroma_out <= y_next;
    end
  end
endmodule

// File: rtl/chroma_qmod_chk.sv
module chroma_qmod_chk #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 10,
  parameter int OUT_W = 10,
  parameter int SUM_W = 20
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    pix_en,
  input logic                    line_start,
  input logic                    pal_mode,
  input logic                    line_reset,
  input logic [ACC_W-1:0]        freq_inc,
  input logic [ACC_W-1:0]        acc_q,
  input logic [PH_W-1:0]         ofs_q,
  input logic                    alt_q,
  input logic signed [SUM_W-1:0] sum_rnd,
  input logic signed [OUT_W-1:0] chroma_out,
  input logic                    chroma_vld
);
  localparam logic signed [SUM_W-1:0] Y_MAX = SUM_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] Y_MIN = -SUM_W'(1 << (OUT_W - 1));

  AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en && !line_start |=> acc_q == $past(acc_q) + $past(freq_inc)); // R2
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en && !line_start |=> $stable(acc_q)); // R2
  AST_VLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |=> chroma_vld); // R4
  AST_VLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> !chroma_vld); // R4
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en && sum_rnd > Y_MAX |=> chroma_out == Y_MAX[OUT_W-1:0]); // R5
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en && sum_rnd < Y_MIN |=> chroma_out == Y_MIN[OUT_W-1:0]); // R5
  AST_OFS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(ofs_q)); // R6
  AST_ALT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    line_start && pal_mode |=> alt_q != $past(alt_q)); // R7
  AST_ALT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    line_start && !pal_mode |=> !alt_q); // R8
  AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    line_start && line_reset |=> acc_q == '0); // R9
endmodule

bind chroma_qmod chroma_qmod_chk #(
  .ACC_W(ACC_W), .PH_W(PH_W), .OUT_W(OUT_W), .SUM_W(SUM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_start(line_start),
  .pal_mode(pal_mode), .line_reset(line_reset), .freq_inc(freq_inc),
  .acc_q(acc_q), .ofs_q(ofs_q), .alt_q(alt_q), .sum_rnd(sum_rnd),
  .chroma_out(chroma_out), .chroma_vld(chroma_vld)
);

// File: tb/test_chroma_qmod.sv
module test_chroma_qmod;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_en = 1'b0, line_start = 1'b0, pal_mode = 1'b0, line_reset = 1'b0;
  logic burst_gate = 1'b0;
  logic [31:0] freq_inc = '0;
  logic [9:0]  phase_ofs = '0;
  logic signed [7:0] cb_in = '0, cr_in = '0;
  logic signed [9:0] chroma_out;
  logic chroma_vld;

  always #10 clk = ~clk;   // 50 MHz

  chroma_qmod i_chroma_qmod (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_start(line_start),
    .pal_mode(pal_mode), .line_reset(line_reset), .freq_inc(freq_inc),
    .phase_ofs(phase_ofs), .burst_gate(burst_gate), .cb_in(cb_in),
    .cr_in(cr_in), .chroma_out(chroma_out), .chroma_vld(chroma_vld)
  );

  typedef struct { int val; string tag; } exp_t;
  exp_t sb[$];
  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit done = 1'b0;

  // independent reference model state
  logic [31:0] m_acc = '0;
  logic [9:0]  m_ofs = '0;
  bit          m_alt = 1'b0;

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // half-wave sine on a 10-bit angle, evaluated without quadrant folding
  function automatic int ref_sin(logic [9:0] ang);
    longint a, p, m;
    a = 2 * longint'(ang[8:0]) + 1;
    p = a * (1024 - a);
    m = (8176 * p) / (5242880 - 4 * p);
    return ang[9] ? -int'(m) : int'(m);
  endfunction

  function automatic int ref_out(int u, int v, logic [9:0] ang);
    int s, c, t, q;
    s = ref_sin(ang);
    c = ref_sin(ang + 10'd256);
    t = u * s + v * c + 64;
    q = (t >= 0) ? t / 128 : -((-t + 127) / 128);
    if (q > 511) q = 511;
    if (q < -512) q = -512;
    return q;
  endfunction

  task automatic step(bit pe, bit ls, bit bg, int b, int r, string tag);
    int u, v;
    exp_t e;
    @(negedge clk);
    pix_en = pe; line_start = ls; burst_gate = bg;
    cb_in = 8'(b); cr_in = 8'(r);
    if (pe) begin
      u = bg ? -48 : b;
      v = bg ? (pal_mode ? 48 : 0) : r;
      if (pal_mode && m_alt) v = -v;
      e.val = ref_out(u, v, m_acc[31:22] + m_ofs);
      e.tag = tag;
      sb.push_back(e);
    end
    if (ls && line_reset) m_acc = '0;
    else if (pe)          m_acc = m_acc + freq_inc;
    if (ls) begin
      m_ofs = phase_ofs;
      m_alt = pal_mode ? ~m_alt : 1'b0;
    end
  endtask

  // monitor: pop and compare each produced sample
  always @(negedge clk) begin
    if (rst_n && chroma_vld) begin
      if (sb.size() == 0) check("R4 unexpected vld", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, int'(chroma_out), e.val);
      end
    end
  end

  task automatic flush();
    repeat (3) step(0, 0, 0, 0, 0, "");
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset out", int'(chroma_out), 0);
    check("R1 reset vld", int'(chroma_vld), 0);
    @(negedge clk); rst_n = 1'b1;

    // R1/R3: zero phase after reset, pure Cr on cosine peak
    step(1, 0, 0, 0, 100, "R1 first phase");
    step(1, 0, 0, 100, 0, "R3 sine zero");
    flush();

    // R2/R3/R4: NTSC-like increment, varied samples
    freq_inc = 32'h21F07C1F;
    for (int i = 0; i < 300; i++)
      step(1, 0, 0, $signed(8'($urandom)), $signed(8'($urandom)), "R2 R3 R4 ntsc");
    // R2: gaps in pix_en hold the phase
    for (int i = 0; i < 40; i++)
      step(i % 3 == 0, 0, 0, 50 - i, i - 20, "R2 gaps");
    flush();

    // R6: offset written mid-line waits for line start
    phase_ofs = 10'd300;
    for (int i = 0; i < 20; i++) step(1, 0, 0, 70, -40, "R6 before line");
    step(1, 1, 0, 70, -40, "R6 at line");
    for (int i = 0; i < 20; i++) step(1, 0, 0, 70, -40, "R6 after line");

    // R9: line reset clears the accumulator; R9 off keeps it running
    line_reset = 1'b1;
    step(1, 1, 0, -90, 60, "R9 reset line");
    for (int i = 0; i < 10; i++) step(1, 0, 0, -90, 60, "R9 after reset");
    line_reset = 1'b0;
    step(1, 1, 0, -90, 60, "R9 no reset");
    for (int i = 0; i < 10; i++) step(1, 0, 0, -90, 60, "R9 running");

    // R5: saturation at 45 and 225 degrees
    freq_inc = '0; line_reset = 1'b1; phase_ofs = 10'd128;
    step(0, 1, 0, 0, 0, "");
    step(1, 0, 0, 127, 127, "R5 sat high");
    step(1, 0, 0, -128, -128, "R5 sat low");
    phase_ofs = 10'd640;
    step(0, 1, 0, 0, 0, "");
    step(1, 0, 0, 127, 127, "R5 sat low b");
    step(1, 0, 0, -128, -128, "R5 sat high b");
    flush();

    // R7/R10: PAL lines with burst then picture
    pal_mode = 1'b1; line_reset = 1'b0; phase_ofs = 10'd37;
    freq_inc = 32'h2A098ACB;
    for (int ln = 0; ln < 6; ln++) begin
      step(1, 1, 1, 0, 0, "R7 R10 pal burst");
      for (int i = 0; i < 8; i++)  step(1, 0, 1, 0, 0, "R10 pal burst");
      for (int i = 0; i < 20; i++)
        step(1, 0, 0, $signed(8'($urandom)), $signed(8'($urandom)), "R7 pal pic");
    end

    // R8/R10: back to NTSC, no Cr inversion, burst Cr is zero
    pal_mode = 1'b0;
    for (int ln = 0; ln < 3; ln++) begin
      step(1, 1, 1, 0, 0, "R8 R10 ntsc burst");
      for (int i = 0; i < 6; i++) step(1, 0, 1, 0, 0, "R10 ntsc burst");
      for (int i = 0; i < 15; i++) step(1, 0, 0, -20, 110, "R8 ntsc pic");
    end
    flush();
    check("R4 scoreboard drained", sb.size(), 0);
    summary();
  end
endmodule